// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block sequences the reset of an embedded processor. It has two paths. A cold reset comes from a power-on input. A warm reset comes from one of three sources: the shared reset line pulled low by another device, a one-cycle software request, or a one-cycle bus time-out. The block pulls the shared reset line low through an open-drain style output. It sets the direction of the data-bus transceiver and enables the block's own data-bus drivers. It also gates the memory control strobes.

While the cold input is held low, the bus is turned inbound and a 16-bit boot word is read from it. Every phase after that is timed by a down-counter. The length of each phase is a long count or a short count, chosen by one bit of the captured boot word. At the end of the sequence the block raises a one-cycle pulse that requests either a hard or a soft reset exception. After the block releases the reset line it ignores that line for one count window, so that a pull-up has time to bring the line high.

Top module: `rst_seq_top`

## Requirements
- R1: While `cold_rst_ni` is low, the block drives `rst_drive_o`=1. It also drives `bus_oe_o`=0 (own drivers tri-stated), `boot_oe_no`=0, `bus_dir_o`=0 (inbound) and `mem_strobe_en_o`=0. The same outputs are driven while `rst_ni` is low.
- R2: While `cold_rst_ni` is low, the block samples `bus_data_i` on every clock. `boot_cfg_o` keeps the last value sampled before `cold_rst_ni` is seen high. Later bus activity does not change it.
- R3: In the first cycle after `cold_rst_ni` is seen high, the block drives `bus_oe_o`=1, `boot_oe_no`=1 and `bus_dir_o`=1, and keeps `rst_drive_o`=1.
- R4: After the cold release, `rst_drive_o` stays 1 for exactly N cycles and then drops to 0.
- R5: For N cycles after a cold release of the reset line, a low level on `rst_pin_i` has no effect. After that window, a low level on `rst_pin_i` starts a warm reset.
- R6: In the run state, a warm reset starts from any of three requests: `rst_pin_i` low, seen after a two-flop synchronizer (three cycles from pin to hold); an `sw_rst_req_i` pulse (one cycle); or a `bus_tmo_i` pulse (one cycle).
- R7: The warm hold phase lasts N cycles. During it the block drives `rst_drive_o`=1, `bus_oe_o`=0, `mem_strobe_en_o`=0, `bus_dir_o`=1 and `boot_oe_no`=1.
- R8: After the warm hold, the block releases the line and drives the bus again (`bus_oe_o`=1, `mem_strobe_en_o`=1). It then ignores `rst_pin_i` for N cycles and returns to the run state.
- R9: `hard_exc_o` pulses for one cycle in the last cycle of the cold count. `soft_exc_o` pulses for one cycle in the last cycle of the warm ignore window. The two pulses are never high together.
- R10: `cold_rst_ni` low takes priority over every warm source in every state. It aborts a warm sequence and restarts the cold sequence.
- R11: N is 64 when bit `FAST_BIT` (default 0) of the captured boot word is 1, and 4096 when that bit is 0. The captured word stays on `boot_cfg_o` until the next cold reset.
- R12: Software and time-out requests that arrive while a sequence is running are ignored. They do not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| cold_rst_ni | input | 1 | Power-on cold reset request, active low |
| rst_pin_i | input | 1 | Sensed level of the shared reset line |
| sw_rst_req_i | input | 1 | Software warm-reset request, one-cycle pulse |
| bus_tmo_i | input | 1 | Bus transaction time-out, one-cycle pulse |
| bus_data_i | input | 16 | Low half of the data bus, read for the boot word |
| rst_drive_o | output | 1 | 1 pulls the shared reset line low |
| bus_oe_o | output | 1 | Enable of the block's own data-bus drivers |
| boot_oe_no | output | 1 | Boot word output-enable, active low |
| bus_dir_o | output | 1 | Transceiver direction, 0 inbound, 1 outbound |
| mem_strobe_en_o | output | 1 | 0 forces all memory control strobes inactive |
| boot_cfg_o | output | 16 | Captured boot configuration word |
| hard_exc_o | output | 1 | Hard reset exception request pulse |
| soft_exc_o | output | 1 | Soft reset exception request pulse |

## Verification
The hardest case to reach is a low level on the reset line during one of the ignore windows. The block's own drive has only just been removed, and the synchronizer still holds old values. The bench models the line as a wired-AND of the block's drive and an external pull-down. It pulls the line low part-way through each ignore window and lets it go again well before the window ends. It then checks that the sequence keeps its exact cycle timing and that no new warm reset follows. A second hard case is a request that arrives while a sequence is already running. The bench injects a software pulse during a warm hold and a cold assertion in the middle of a warm sequence. It then checks the exact cycle of the exception pulse.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_COLD_HOLD,
    ST_COLD_WAIT,
    ST_COLD_IGN,
    ST_RUN,
    ST_WARM_HOLD,
    ST_WARM_IGN
  } seq_state_e;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  output logic done_o
);
  localparam int CW = $clog2(LONG_CYC);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt_q;

  // loaded on phase entry, so a phase lasts exactly the load value + 1 cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= fast_i ? SHORT_LD : LONG_LD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_no_early_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/rst_seq_boot_cap.sv
module rst_seq_boot_cap #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_o <= '0;
    else if (cap_en_i) word_o <= data_i;
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> word_o == $past(data_i));
  assert_word_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_i |=> $stable(word_o));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cold_ni,
  input  logic pin_lvl_i,
  input  logic sw_req_i,
  input  logic tmo_req_i,
  input  logic done_i,
  output logic start_o,
  output logic cap_en_o,
  output logic rst_drive_o,
  output logic bus_oe_o,
  output logic boot_oe_no,
  output logic bus_dir_o,
  output logic mem_strobe_en_o,
  output logic hard_exc_o,
  output logic soft_exc_o
);
  seq_state_e state_q, state_d;
  logic warm_req;

  assign warm_req = !pin_lvl_i || sw_req_i || tmo_req_i;

  always_comb begin
    state_d    = state_q;
    start_o    = 1'b0;
    hard_exc_o = 1'b0;
    soft_exc_o = 1'b0;
    if (!cold_ni) begin
      state_d = ST_COLD_HOLD;
    end else begin
      unique case (state_q)
        ST_COLD_HOLD: begin
          state_d = ST_COLD_WAIT;
          start_o = 1'b1;
        end
        ST_COLD_WAIT: if (done_i) begin
          state_d    = ST_COLD_IGN;
          start_o    = 1'b1;
          hard_exc_o = 1'b1;
        end
        ST_COLD_IGN: if (done_i) state_d = ST_RUN;
        ST_RUN: if (warm_req) begin
          state_d = ST_WARM_HOLD;
          start_o = 1'b1;
        end
        ST_WARM_HOLD: if (done_i) begin
          state_d = ST_WARM_IGN;
          start_o = 1'b1;
        end
        ST_WARM_IGN: if (done_i) begin
          state_d    = ST_RUN;
          soft_exc_o = 1'b1;
        end
        default: state_d = ST_COLD_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_COLD_HOLD;
    else         state_q <= state_d;
  end

  always_comb begin
    rst_drive_o = (state_q == ST_COLD_HOLD) || (state_q == ST_COLD_WAIT) ||
                  (state_q == ST_WARM_HOLD);
    bus_oe_o    = (state_q != ST_COLD_HOLD) && (state_q != ST_WARM_HOLD);
    boot_oe_no  = (state_q != ST_COLD_HOLD);
    bus_dir_o   = (state_q != ST_COLD_HOLD);
    mem_strobe_en_o = !rst_drive_o;
  end

  assign cap_en_o = (state_q == ST_COLD_HOLD) && !cold_ni;

  assert_cold_prio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_ni |=> state_q == ST_COLD_HOLD);
  assert_warm_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cold_ni && (sw_req_i || tmo_req_i)) |=> state_q == ST_WARM_HOLD);
  assert_busy_ignore_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WARM_HOLD && cold_ni && !done_i) |=> state_q == ST_WARM_HOLD);
  assert_exc_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hard_exc_o && soft_exc_o));
  assert_soft_to_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_exc_o |=> state_q == ST_RUN && !rst_drive_o);
  assert_line_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_exc_o |=> !rst_drive_o && bus_oe_o);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int BOOT_W    = 16,
  parameter int FAST_BIT  = 0,
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 64,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_rst_ni,
  input  logic              rst_pin_i,
  input  logic              sw_rst_req_i,
  input  logic              bus_tmo_i,
  input  logic [BOOT_W-1:0] bus_data_i,
  output logic              rst_drive_o,
  output logic              bus_oe_o,
  output logic              boot_oe_no,
  output logic              bus_dir_o,
  output logic              mem_strobe_en_o,
  output logic [BOOT_W-1:0] boot_cfg_o,
  output logic              hard_exc_o,
  output logic              soft_exc_o
);
  logic pin_s, start, done, cap_en;

  rst_seq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_i), .q_o(pin_s)
  );

  rst_seq_boot_cap #(.W(BOOT_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_en_i(cap_en),
    .data_i(bus_data_i), .word_o(boot_cfg_o)
  );

  rst_seq_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .fast_i(boot_cfg_o[FAST_BIT]), .done_o(done)
  );

  rst_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cold_ni(cold_rst_ni),
    .pin_lvl_i(pin_s), .sw_req_i(sw_rst_req_i), .tmo_req_i(bus_tmo_i),
    .done_i(done), .start_o(start), .cap_en_o(cap_en),
    .rst_drive_o(rst_drive_o), .bus_oe_o(bus_oe_o), .boot_oe_no(boot_oe_no),
    .bus_dir_o(bus_dir_o), .mem_strobe_en_o(mem_strobe_en_o),
    .hard_exc_o(hard_exc_o), .soft_exc_o(soft_exc_o)
  );
endmodule

// File: tb/rst_seq_top_tb.sv
module rst_seq_top_tb;
  localparam int LONG_N  = 4096;
  localparam int SHORT_N = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cold_rst_ni = 1'b0;
  logic ext_low = 1'b0;
  logic sw_rst_req = 1'b0;
  logic bus_tmo = 1'b0;
  logic [15:0] bus_data = 16'h0;
  logic rst_drive, bus_oe, boot_oe_n, bus_dir, mem_en, hard_exc, soft_exc;
  logic [15:0] boot_cfg;
  logic rst_pin;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  // wired-AND model of the shared reset line
  assign rst_pin = !(rst_drive || ext_low);

  rst_seq_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cold_rst_ni(cold_rst_ni), .rst_pin_i(rst_pin),
    .sw_rst_req_i(sw_rst_req), .bus_tmo_i(bus_tmo), .bus_data_i(bus_data),
    .rst_drive_o(rst_drive), .bus_oe_o(bus_oe), .boot_oe_no(boot_oe_n),
    .bus_dir_o(bus_dir), .mem_strobe_en_o(mem_en), .boot_cfg_o(boot_cfg),
    .hard_exc_o(hard_exc), .soft_exc_o(soft_exc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_cold_hold(input string req);
    chk({req, " drive"}, rst_drive, 1);
    chk({req, " bus_oe"}, bus_oe, 0);
    chk({req, " boot_oe_n"}, boot_oe_n, 0);
    chk({req, " dir"}, bus_dir, 0);
    chk({req, " mem_en"}, mem_en, 0);
  endtask

  // cold sequence; leaves the block in run state
  task automatic cold_seq(input logic [15:0] word, input int n);
    @(negedge clk);
    cold_rst_ni = 1'b0;
    bus_data = ~word;
    repeat (3) @(negedge clk);
    chk_cold_hold("R1 cold hold");
    bus_data = word;
    @(negedge clk);
    cold_rst_ni = 1'b1;
    bus_data = ~word;
    for (int k = 1; k <= 2 * n + 4; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk("R3 drive", rst_drive, 1);
        chk("R3 bus_oe", bus_oe, 1);
        chk("R3 boot_oe_n", boot_oe_n, 1);
        chk("R3 dir", bus_dir, 1);
        chk("R2 boot word", boot_cfg, word);
      end
      if (k == n - 1) begin
        chk("R4 drive before end", rst_drive, 1);
        chk("R9 hard early", hard_exc, 0);
      end
      if (k == n) begin
        chk("R11/R4 drive last", rst_drive, 1);
        chk("R9 hard pulse", hard_exc, 1);
        chk("R9 no soft", soft_exc, 0);
      end
      if (k == n + 1) begin
        chk("R4 released", rst_drive, 0);
        chk("R9 hard one cycle", hard_exc, 0);
        ext_low = 1'b1;
      end
      if (k == 2 * n - 7) ext_low = 1'b0;
      if (k == 2 * n + 4) begin
        chk("R5 pin ignored", rst_drive, 0);
        chk("R5 bus kept", bus_oe, 1);
        chk("R11 boot held", boot_cfg, word);
      end
    end
  endtask

  // kind 0: pin, 1: software, 2: time-out
  task automatic warm_seq(input int kind, input int n, input logic [15:0] word);
    int d;
    d = (kind == 0) ? 3 : 1;
    @(negedge clk);
    if (kind == 0) ext_low = 1'b1;
    if (kind == 1) sw_rst_req = 1'b1;
    if (kind == 2) bus_tmo = 1'b1;
    for (int m = 1; m <= d + 2 * n + 3; m++) begin
      @(negedge clk);
      if (m == 1) begin
        sw_rst_req = 1'b0;
        bus_tmo = 1'b0;
      end
      if (kind == 0 && m == 2) chk("R6 sync latency", rst_drive, 0);
      if (m == d) begin
        chk("R6 warm entered", rst_drive, 1);
        chk("R7 bus tri", bus_oe, 0);
        chk("R7 strobes off", mem_en, 0);
        chk("R7 dir", bus_dir, 1);
        chk("R7 boot_oe_n", boot_oe_n, 1);
        ext_low = 1'b0;
      end
      if (m == d + 2) sw_rst_req = 1'b1;
      if (m == d + 3) sw_rst_req = 1'b0;
      if (m == d + n - 1) chk("R7 hold length", rst_drive, 1);
      if (m == d + n) begin
        chk("R8 released", rst_drive, 0);
        chk("R8 bus back", bus_oe, 1);
        chk("R8 strobes on", mem_en, 1);
        ext_low = 1'b1;
      end
      if (m == d + n + 5) ext_low = 1'b0;
      if (m == d + 2 * n - 2) chk("R12 no restart", soft_exc, 0);
      if (m == d + 2 * n - 1) begin
        chk("R9 soft pulse", soft_exc, 1);
        chk("R9 no hard", hard_exc, 0);
      end
      if (m == d + 2 * n + 3) begin
        chk("R8 pin ignored", rst_drive, 0);
        chk("R8 soft one cycle", soft_exc, 0);
        chk("R11 boot held warm", boot_cfg, word);
      end
    end
  endtask

  task automatic cold_abort();
    @(negedge clk);
    sw_rst_req = 1'b1;
    @(negedge clk);
    sw_rst_req = 1'b0;
    chk("R6 sw warm", rst_drive, 1);
    repeat (8) @(negedge clk);
    cold_rst_ni = 1'b0;
    @(negedge clk);
    chk_cold_hold("R10 abort");
    cold_seq(16'h40C1, SHORT_N);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_cold_hold("R1 reset");
    rst_ni = 1'b1;
    cold_seq(16'h1230, LONG_N);     // bit 0 clear: long count
    cold_seq(16'hA5C1, SHORT_N);    // bit 0 set: short count
    warm_seq(0, SHORT_N, 16'hA5C1);
    warm_seq(1, SHORT_N, 16'hA5C1);
    warm_seq(2, SHORT_N, 16'hA5C1);
    cold_abort();
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule